// File: doc/BRIEF.md
# Seven-Segment Space-Vector Gate Sequencer

This block turns one switching period's worth of space-vector data into gate commands for a three-phase two-level bridge and for one extra series switch in the DC link. At the start of each frame it takes two active-vector codes and their dwell counts, together with the frame length. It then plays a symmetric seven-segment pattern: zero state 000, first active vector, second active vector, zero state 111, second active vector, first active vector, and zero state 000. A new frame follows immediately. Each bridge leg drives complementary upper and lower gates. Whenever a leg changes state, both of its gates stay off for a programmable dead time.

The series DC-link switch is held closed except around the all-upper zero state. Opening it there keeps the bridge from reaching its highest common-mode level. A separate programmable guard widens the open window on both sides of that segment, so the switch never moves in the same cycle as the bridge legs around it. A synchronous reset or a low enable turns every bridge gate off and opens the series switch. The frame length is a plain count of clock cycles, so any switching frequency, such as 15 kHz from the system clock, is reached by choosing that count.

Top module: `svm_gate_seq`

## Requirements
- R1: In the cycle after an edge that sees `rst` high or `en` low, all six gate outputs are 0 and `aux_close` is 0.
- R2: Let hA = floor(`dwell_a`/2), hB = floor(`dwell_b`/2), Z = `period_len` − 2hA − 2hB and q = floor(Z/4). A frame then lasts 2hA + 2hB + Z ticks, played as 000 for q, `vec_a` for hA, `vec_b` for hB, 111 for Z − 2q, `vec_b` for hB, `vec_a` for hA and 000 for q. Segments of length zero are skipped. In a state code, bit 2 is phase a, bit 1 is phase b and bit 0 is phase c. The gates show tick k one clock edge after the edge that steps the sequencer through tick k.
- R3: A leg whose commanded bit is 1 drives `gate_hi` and not `gate_lo`; a bit of 0 drives `gate_lo` and not `gate_hi`. Both gates of a leg are never on together.
- R4: When a leg's commanded bit changes, both of its gates are off for exactly `dead_len` cycles, then the new gate turns on. A change during that gap restarts the gap. A `dead_len` of 0 gives no gap.
- R5: `aux_close` is 0 for every tick t of a frame with b3 − G ≤ t < b4 + G, where b3 and b4 are the start and end ticks of the 111 segment and G = `aux_guard`. This applies only when that segment has nonzero length; outside that window `aux_close` is 1 while enabled.
- R6: Dwell counts, vector codes and frame length are sampled only at a frame start. Changes to them during a frame have no effect until the next frame.
- R7: When 2hA + 2hB exceeds `period_len`, Z is taken as 0. The frame then stretches to 2hA + 2hB ticks and holds no zero-state segments.
- R8: The first frame after enable starts from tick 0 with no dead time on its initial state. If q > 0, the lower gates are all on one cycle after the edge that loads the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Synchronous run enable |
| period_len | input | CNT_W | Frame length in clock cycles |
| dwell_a | input | CNT_W | Total dwell of the first active vector |
| dwell_b | input | CNT_W | Total dwell of the second active vector |
| vec_a | input | 3 | First active vector code (a,b,c) |
| vec_b | input | 3 | Second active vector code (a,b,c) |
| dead_len | input | DT_W | Leg dead time in cycles |
| aux_guard | input | DT_W | Guard cycles around the series-switch opening |
| gate_hi | output | 3 | Upper gates, bit 2 = phase a |
| gate_lo | output | 3 | Lower gates, bit 2 = phase a |
| aux_close | output | 1 | 1 closes the DC-link series switch |

## Verification
Every output is due one rising edge after the edge that advances the frame tick it shows. This holds for the gates, the series switch, and the forced-off state after a reset or disable. A dead-time gap ends `dead_len` edges after the change that started it. The bench keeps a reference frame tracker that it updates on the same rising edge as the design. It compares the outputs on the following falling edge, so each comparison sees the register stage that tick has just passed through. Inputs change only on falling edges, and dead time and guard change only while the block is disabled.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;

  typedef enum logic [2:0] {
    SEG_Z0_HEAD = 3'd0,
    SEG_A_UP    = 3'd1,
    SEG_B_UP    = 3'd2,
    SEG_Z7      = 3'd3,
    SEG_B_DN    = 3'd4,
    SEG_A_DN    = 3'd5,
    SEG_Z0_TAIL = 3'd6
  } seg_e;

  localparam logic [2:0] CODE_ALL_LO = 3'b000;
  localparam logic [2:0] CODE_ALL_HI = 3'b111;
  localparam int         NUM_SEG     = 7;

  // half of a total active dwell, one half per side of the centre
  function automatic int unsigned half_dwell(int unsigned d);
    return d >> 1;
  endfunction

  // period time left for both zero states, saturating at zero
  function automatic int unsigned zero_span(int unsigned p, int unsigned ha, int unsigned hb);
    int unsigned act;
    act = 2 * ha + 2 * hb;
    return (p > act) ? (p - act) : 0;
  endfunction

  // each all-zeros end segment takes a quarter of the zero time
  function automatic int unsigned edge_zero(int unsigned z);
    return z >> 2;
  endfunction

endpackage

// File: rtl/svm_frame_timer.sv
module svm_frame_timer
  import svm_seq_pkg::*;
#(
  parameter int CNT_W = 14,
  localparam int TW = CNT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [CNT_W-1:0]          period_len,
  input  logic [CNT_W-1:0]          dwell_a,
  input  logic [CNT_W-1:0]          dwell_b,
  input  logic [2:0]                vec_a,
  input  logic [2:0]                vec_b,
  output logic                      run_q,
  output logic [TW-1:0]             tick_q,
  output logic [NUM_SEG-1:0][TW-1:0] ends_q,
  output logic [2:0]                code_a_q,
  output logic [2:0]                code_b_q
);

  logic [NUM_SEG-1:0][TW-1:0] ends_nxt;
  logic                       wrap;
  logic                       load;

  // cumulative segment end ticks for the frame about to start
  always_comb begin
    int unsigned ha, hb, z, q, acc;
    int unsigned lens [NUM_SEG];
    ha = half_dwell(32'(dwell_a));
    hb = half_dwell(32'(dwell_b));
    z  = zero_span(32'(period_len), ha, hb);
    q  = edge_zero(z);
    lens[0] = q;  lens[1] = ha; lens[2] = hb; lens[3] = z - 2 * q;
    lens[4] = hb; lens[5] = ha; lens[6] = q;
    acc = 0;
    for (int s = 0; s < NUM_SEG; s++) begin
      acc = acc + lens[s];
      ends_nxt[s] = TW'(acc);
    end
  end

  assign wrap = run_q && (({1'b0, tick_q} + 1'b1) >= {1'b0, ends_q[NUM_SEG-1]});
  assign load = !run_q || wrap;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q  <= 1'b0;
      tick_q <= '0;
    end else if (load) begin
      run_q    <= 1'b1;
      tick_q   <= '0;
      ends_q   <= ends_nxt;
      code_a_q <= vec_a;
      code_b_q <= vec_b;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  AST_TICK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (run_q && ends_q[NUM_SEG-1] != '0) |-> (tick_q < ends_q[NUM_SEG-1])); // R2

  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && !wrap) |=> ($stable(ends_q) && $stable(code_a_q) && $stable(code_b_q))); // R6

endmodule

// File: rtl/svm_leg_dt.sv
module svm_leg_dt #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            act,
  input  logic            want,
  input  logic [DT_W-1:0] dead_len,
  output logic            hi,
  output logic            lo
);

  logic            on_q;
  logic            cur_q;
  logic [DT_W-1:0] gap_q;
  logic            gap_done;

  assign gap_done = (gap_q == '0);

  always_ff @(posedge clk) begin
    if (!act) begin
      on_q  <= 1'b0;
      cur_q <= 1'b0;
      gap_q <= '0;
    end else if (!on_q) begin
      on_q  <= 1'b1;
      cur_q <= want;
      gap_q <= '0;
    end else if (want != cur_q) begin
      cur_q <= want;
      gap_q <= dead_len;
    end else if (!gap_done) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign hi = on_q && cur_q && gap_done;
  assign lo = on_q && !cur_q && gap_done;

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!act)
    !(hi && lo)); // R3

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!act)
    (on_q && want != cur_q && dead_len != '0) |=> (!hi && !lo)); // R4

endmodule

// File: rtl/svm_gate_seq.sv
module svm_gate_seq
  import svm_seq_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period_len,
  input  logic [CNT_W-1:0] dwell_a,
  input  logic [CNT_W-1:0] dwell_b,
  input  logic [2:0]       vec_a,
  input  logic [2:0]       vec_b,
  input  logic [DT_W-1:0]  dead_len,
  input  logic [DT_W-1:0]  aux_guard,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo,
  output logic             aux_close
);

  localparam int TW = CNT_W + 1;
  localparam int WW = TW + 1;

  logic                       run;
  logic [TW-1:0]              tick;
  logic [NUM_SEG-1:0][TW-1:0] ends;
  logic [2:0]                 code_a;
  logic [2:0]                 code_b;
  logic                       act;
  seg_e                       seg;
  logic [2:0]                 tgt;
  logic                       z7_present;
  logic                       aux_window;
  logic                       aux_q;

  svm_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .en(en),
    .period_len(period_len), .dwell_a(dwell_a), .dwell_b(dwell_b),
    .vec_a(vec_a), .vec_b(vec_b),
    .run_q(run), .tick_q(tick), .ends_q(ends),
    .code_a_q(code_a), .code_b_q(code_b)
  );

  assign act = run && en && !rst;

  // segment lookup: first end tick beyond the current tick
  always_comb begin
    if      (tick < ends[0]) seg = SEG_Z0_HEAD;
    else if (tick < ends[1]) seg = SEG_A_UP;
    else if (tick < ends[2]) seg = SEG_B_UP;
    else if (tick < ends[3]) seg = SEG_Z7;
    else if (tick < ends[4]) seg = SEG_B_DN;
    else if (tick < ends[5]) seg = SEG_A_DN;
    else                     seg = SEG_Z0_TAIL;
  end

  always_comb begin
    unique case (seg)
      SEG_A_UP, SEG_A_DN: tgt = code_a;
      SEG_B_UP, SEG_B_DN: tgt = code_b;
      SEG_Z7:             tgt = CODE_ALL_HI;
      default:            tgt = CODE_ALL_LO;
    endcase
  end

  // series switch opens around the all-upper segment, widened by the guard
  assign z7_present = (ends[3] != ends[2]);
  assign aux_window = z7_present &&
    (({1'b0, tick} + WW'(aux_guard)) >= {1'b0, ends[2]}) &&
    ({1'b0, tick} < ({1'b0, ends[3]} + WW'(aux_guard)));

  always_ff @(posedge clk) begin
    aux_q <= act && !aux_window;
  end

  assign aux_close = aux_q;

  for (genvar g = 0; g < 3; g++) begin : g_leg
    svm_leg_dt #(.DT_W(DT_W)) u_leg (
      .clk(clk), .act(act), .want(tgt[g]), .dead_len(dead_len),
      .hi(gate_hi[g]), .lo(gate_lo[g])
    );
  end

  AST_CLEAR_OFF: assert property (@(posedge clk)
    (rst || !en) |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && !aux_close)); // R1

  AST_Z7_AUX_OPEN: assert property (@(posedge clk) disable iff (rst)
    (act && tgt == CODE_ALL_HI) |=> !aux_close); // R5

endmodule

// File: tb/svm_gate_seq_tb_top.sv
module svm_gate_seq_tb_top;

  localparam int CNT_W = 6;
  localparam int DT_W  = 3;
  localparam int AGE_CAP = 1000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [CNT_W-1:0] period_len = '0;
  logic [CNT_W-1:0] dwell_a = '0;
  logic [CNT_W-1:0] dwell_b = '0;
  logic [2:0]       vec_a = 3'b100;
  logic [2:0]       vec_b = 3'b110;
  logic [DT_W-1:0]  dead_len = '0;
  logic [DT_W-1:0]  aux_guard = '0;
  logic [2:0]       gate_hi;
  logic [2:0]       gate_lo;
  logic             aux_close;

  always #5 clk = ~clk;

  svm_gate_seq #(.CNT_W(CNT_W), .DT_W(DT_W)) dut_i (
    .clk(clk), .rst(rst), .en(en),
    .period_len(period_len), .dwell_a(dwell_a), .dwell_b(dwell_b),
    .vec_a(vec_a), .vec_b(vec_b), .dead_len(dead_len), .aux_guard(aux_guard),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .aux_close(aux_close)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    chk_on  = 1'b0;
  bit    done    = 1'b0;
  string tag     = "R2";

  // reference frame tracker, restated from the requirements
  bit       m_run = 1'b0;
  int       m_t = 0, m_len = 0;
  int       m_ha = 0, m_hb = 0, m_z = 0;
  logic [2:0] m_ca = 3'b0, m_cb = 3'b0;
  bit       m_on = 1'b0;
  logic [2:0] m_prev = 3'b0;
  int       m_age [3];
  logic [2:0] e_hi = 3'b0, e_lo = 3'b0;
  logic       e_aux = 1'b0;

  function automatic logic [2:0] ref_code(int t);
    int lens [7];
    logic [2:0] codes [7];
    int acc;
    int q;
    q = m_z / 4;
    lens  = '{q, m_ha, m_hb, m_z - 2 * q, m_hb, m_ha, q};
    codes = '{3'b000, m_ca, m_cb, 3'b111, m_cb, m_ca, 3'b000};
    acc = 0;
    for (int s = 0; s < 7; s++) begin
      if (t < acc + lens[s]) return codes[s];
      acc += lens[s];
    end
    return 3'b000;
  endfunction

  function automatic bit ref_open(int t, int g);
    int q, s7, e7;
    q  = m_z / 4;
    s7 = q + m_ha + m_hb;
    e7 = s7 + (m_z - 2 * q);
    return (e7 > s7) && (t + g >= s7) && (t < e7 + g);
  endfunction

  always @(posedge clk) begin
    bit a;
    logic [2:0] tg;
    int sum;
    a = m_run && en && !rst;
    if (a) begin
      tg = ref_code(m_t);
      for (int i = 0; i < 3; i++) begin
        if (!m_on)                m_age[i] = AGE_CAP;
        else if (tg[i] != m_prev[i]) m_age[i] = 0;
        else if (m_age[i] < AGE_CAP) m_age[i] = m_age[i] + 1;
        e_hi[i] = tg[i] && (m_age[i] >= int'(dead_len));
        e_lo[i] = !tg[i] && (m_age[i] >= int'(dead_len));
      end
      e_aux  = !ref_open(m_t, int'(aux_guard));
      m_on   = 1'b1;
      m_prev = tg;
    end else begin
      e_hi = 3'b0; e_lo = 3'b0; e_aux = 1'b0; m_on = 1'b0;
    end
    if (rst || !en) begin
      m_run = 1'b0; m_t = 0;
    end else if (!m_run || (m_t + 1 >= m_len)) begin
      m_ha = int'(dwell_a) / 2;
      m_hb = int'(dwell_b) / 2;
      sum  = 2 * m_ha + 2 * m_hb;
      m_z  = (int'(period_len) > sum) ? int'(period_len) - sum : 0;
      m_len = sum + m_z;
      m_ca = vec_a; m_cb = vec_b;
      m_run = 1'b1; m_t = 0;
    end else begin
      m_t = m_t + 1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_tests++;
      if (gate_hi !== e_hi || gate_lo !== e_lo) begin
        n_fail++;
        $display("FAIL R2 R4 %s gates: hi=%b lo=%b expected hi=%b lo=%b", tag, gate_hi, gate_lo, e_hi, e_lo);
      end
      n_tests++;
      if (aux_close !== e_aux) begin
        n_fail++;
        $display("FAIL R5 %s aux_close: got %b expected %b", tag, aux_close, e_aux);
      end
      n_tests++;
      if ((gate_hi & gate_lo) != 3'b000) begin
        n_fail++;
        $display("FAIL R3 leg overlap: hi=%b lo=%b expected no common bit", gate_hi, gate_lo);
      end
    end
  end

  task automatic check_off(string req);
    n_tests++;
    if (gate_hi !== 3'b000 || gate_lo !== 3'b000 || aux_close !== 1'b0) begin
      n_fail++;
      $display("FAIL %s forced off: hi=%b lo=%b aux=%b expected 000 000 0", req, gate_hi, gate_lo, aux_close);
    end
  endtask

  localparam logic [2:0] SEC_A [6] = '{3'b100, 3'b010, 3'b010, 3'b001, 3'b001, 3'b100};
  localparam logic [2:0] SEC_B [6] = '{3'b110, 3'b110, 3'b011, 3'b011, 3'b101, 3'b101};

  task automatic run_cfg(int sec, int da, int db, int p, int dt, int gd, int cyc);
    int ha, hb, z;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_off("R1");
    vec_a = SEC_A[sec]; vec_b = SEC_B[sec];
    dwell_a = CNT_W'(da); dwell_b = CNT_W'(db); period_len = CNT_W'(p);
    dead_len = DT_W'(dt); aux_guard = DT_W'(gd);
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ha = da / 2; hb = db / 2;
    z  = (p > 2 * ha + 2 * hb) ? p - 2 * ha - 2 * hb : 0;
    if (z >= 4) begin
      n_tests++;
      if (gate_lo !== 3'b111 || gate_hi !== 3'b000) begin
        n_fail++;
        $display("FAIL R8 first tick: hi=%b lo=%b expected hi=000 lo=111", gate_hi, gate_lo);
      end
    end
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    int idx;
    m_age = '{AGE_CAP, AGE_CAP, AGE_CAP};
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    check_off("R1");
    rst = 1'b0;

    // near-exhaustive sweep over sectors, dwells, dead time and guard
    tag = "R2";
    idx = 0;
    for (int s = 0; s < 6; s++)
      for (int da = 0; da < 30; da += 3)
        for (int db = 0; db < 30; db += 5) begin
          run_cfg(s, da, db, (idx % 2 == 1) ? 40 : 33, idx % 3, idx % 4, 90);
          idx++;
        end

    // dwell sum above the period
    tag = "R7";
    run_cfg(0, 50, 40, 20, 1, 2, 200);
    run_cfg(3, 30, 31, 10, 0, 0, 120);

    // inputs moving during frames
    tag = "R6";
    run_cfg(2, 10, 12, 45, 2, 1, 10);
    for (int k = 0; k < 60; k++) begin
      repeat (7) @(negedge clk);
      dwell_a = CNT_W'((k * 5) % 40);
      dwell_b = CNT_W'((k * 3) % 30);
      vec_a = SEC_A[k % 6]; vec_b = SEC_B[k % 6];
      period_len = CNT_W'(30 + k % 20);
    end
    repeat (60) @(negedge clk);

    // reset and disable in the middle of a frame
    tag = "R1";
    run_cfg(1, 12, 8, 40, 1, 1, 17);
    rst = 1'b1;
    @(negedge clk);
    check_off("R1");
    rst = 1'b0;
    repeat (23) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_off("R1");
    en = 1'b1;
    repeat (80) @(negedge clk);

    chk_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: run still active, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule